// File: doc/BRIEF.md
# Pipelined Wallace Tree Multiplier

This block multiplies two unsigned operands, 8 bits each by default, and returns the full double-width product. All partial products are formed at the same time, one AND row per multiplier bit. Layers of 3:2 carry-save compressors then reduce these rows until only a sum row and a carry row remain. No carry travels sideways inside any compressor layer.

The sum and carry pair is captured in pipeline registers. A parallel-prefix carry-lookahead adder resolves the pair in the next stage and registers the product. A new operand pair may enter on every clock. Each result appears exactly two cycles after its operands, flagged by an output strobe.

Top module: `wallace_mul_pipe`

## Requirements
- R1: Partial-product row j equals op_a ANDed with bit j of op_b, shifted left by j places; the rows together sum to op_a*op_b.
- R2: Each compressor layer turns every group of three rows into two and passes leftover rows unchanged; the registered sum and carry rows add to op_a*op_b modulo 2^(2W).
- R3: Each compressor bit produces sum = a^b^c in its own column and carry = majority(a,b,c) in the next higher column; operands whose rows collide heavily (such as all ones) still give exact products.
- R4: The final stage adds the registered sum and carry rows with a parallel-prefix lookahead adder; product equals the exact unsigned product of the operands.
- R5: out_valid is high exactly two rising edges after in_valid was sampled high, and is low otherwise.
- R6: A new operand pair is accepted on every cycle; back-to-back pairs each yield their own product, in order, one per cycle.
- R7: A synchronous active-high rst clears both valid stages and all pipeline data registers, so out_valid and product read 0 on the cycle after rst.
- R8: While no valid data reaches a stage, that stage's registers hold their values; product stays unchanged when out_valid is low.
- R9: A zero operand makes every partial-product row zero, so the registered sum and carry rows are both zero and the product is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on op_a/op_b are valid this cycle |
| op_a | input | W (8) | Multiplicand, unsigned |
| op_b | input | W (8) | Multiplier, unsigned |
| out_valid | output | 1 | product holds a new result |
| product | output | 2W (16) | Unsigned product |

## Verification
The bench builds the block with the default W = 8. At that width the whole space of 65,536 operand pairs can be swept back to back. This sweep exercises every collision pattern of the four compressor layers and every carry path of the 16-bit prefix adder. A randomly gapped run and a reset in the middle of traffic then cover the hold behaviour and the clearing of both pipeline stages.

// File: rtl/wmp_pkg.sv
package wmp_pkg;

  // Rows left after one 3:2 layer acting on n rows.
  function automatic int rows_next(input int n);
    return (n / 3) * 2 + (n % 3);
  endfunction

  // Row count after l layers, starting from n rows.
  function automatic int rows_at(input int n, input int l);
    int r;
    r = n;
    for (int k = 0; k < l; k++) r = rows_next(r);
    return r;
  endfunction

  // Layers needed to bring n rows down to two.
  function automatic int layers_for(input int n);
    int r;
    int k;
    r = n;
    k = 0;
    while (r > 2) begin
      r = rows_next(r);
      k++;
    end
    return k;
  endfunction

endpackage

// File: rtl/wmp_pp_gen.sv
module wmp_pp_gen #(
  parameter int W  = 8,
  localparam int PW = 2 * W
) (
  input  logic [W-1:0]          mcand,
  input  logic [W-1:0]          mplier,
  output logic [W-1:0][PW-1:0]  rows
);
  for (genvar j = 0; j < W; j++) begin : g_row
    assign rows[j] = PW'(mcand & {W{mplier[j]}}) << j;
  end
endmodule

// File: rtl/wmp_csa_tree.sv
module wmp_csa_tree
  import wmp_pkg::*;
#(
  parameter int W  = 8,
  localparam int PW = 2 * W,
  localparam int NL = layers_for(W)
) (
  input  logic [W-1:0][PW-1:0] rows_in,
  output logic [PW-1:0]        sum_row,
  output logic [PW-1:0]        carry_row
);
  // Bitwise 3:2 compression: parity stays in place, majority moves up one column.
  function automatic logic [PW-1:0] cmp_sum(input logic [PW-1:0] a, b, c);
    return a ^ b ^ c;
  endfunction

  function automatic logic [PW-1:0] cmp_carry(input logic [PW-1:0] a, b, c);
    return ((a & b) | (b & c) | (a & c)) << 1;
  endfunction

  logic [W-1:0][PW-1:0] lvl [NL+1];

  assign lvl[0] = rows_in;

  for (genvar l = 0; l < NL; l++) begin : g_layer
    localparam int NIN  = rows_at(W, l);
    localparam int NG   = NIN / 3;
    localparam int NOUT = rows_next(NIN);
    for (genvar g = 0; g < NG; g++) begin : g_grp
      assign lvl[l+1][2*g]   = cmp_sum  (lvl[l][3*g], lvl[l][3*g+1], lvl[l][3*g+2]);
      assign lvl[l+1][2*g+1] = cmp_carry(lvl[l][3*g], lvl[l][3*g+1], lvl[l][3*g+2]);
    end
    for (genvar r = 0; r < NIN - 3*NG; r++) begin : g_pass
      assign lvl[l+1][2*NG+r] = lvl[l][3*NG+r];
    end
    for (genvar z = NOUT; z < W; z++) begin : g_zero
      assign lvl[l+1][z] = '0;
    end
  end

  assign sum_row   = lvl[NL][0];
  assign carry_row = lvl[NL][1];
endmodule

// File: rtl/wmp_prefix_add.sv
module wmp_prefix_add #(
  parameter int N  = 16,
  localparam int LV = $clog2(N)
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  output logic [N-1:0] s
);
  logic [N-1:0] gk [LV+1];
  logic [N-1:0] pk [LV+1];
  logic [N-1:0] cin;

  assign gk[0] = x & y;
  assign pk[0] = x ^ y;

  for (genvar k = 0; k < LV; k++) begin : g_lvl
    localparam int D = 1 << k;
    for (genvar i = 0; i < N; i++) begin : g_bit
      if (i >= D) begin : g_merge
        assign gk[k+1][i] = gk[k][i] | (pk[k][i] & gk[k][i-D]);
        assign pk[k+1][i] = pk[k][i] & pk[k][i-D];
      end else begin : g_copy
        assign gk[k+1][i] = gk[k][i];
        assign pk[k+1][i] = pk[k][i];
      end
    end
  end

  // Carry into bit i is the group generate of bits i-1..0; carry out is dropped.
  assign cin = {gk[LV][N-2:0], 1'b0};
  assign s   = pk[0] ^ cin;
endmodule

// File: rtl/wallace_mul_pipe.sv
module wallace_mul_pipe #(
  parameter int W  = 8,
  localparam int PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  output logic          out_valid,
  output logic [PW-1:0] product
);
  logic [W-1:0][PW-1:0] pp_rows;
  logic [PW-1:0] red_sum, red_carry;
  logic [PW-1:0] mid_sum, mid_carry;
  logic          mid_valid;
  logic [PW-1:0] resolved;

  wmp_pp_gen #(.W(W)) u_pp (
    .mcand (op_a),
    .mplier(op_b),
    .rows  (pp_rows)
  );

  wmp_csa_tree #(.W(W)) u_tree (
    .rows_in  (pp_rows),
    .sum_row  (red_sum),
    .carry_row(red_carry)
  );

  // Stage 1: redundant pair
  always_ff @(posedge clk) begin
    if (rst) begin
      mid_valid <= 1'b0;
      mid_sum   <= '0;
      mid_carry <= '0;
    end else begin
      mid_valid <= in_valid;
      if (in_valid) begin
        mid_sum   <= red_sum;
        mid_carry <= red_carry;
      end
    end
  end

  wmp_prefix_add #(.N(PW)) u_add (
    .x(mid_sum),
    .y(mid_carry),
    .s(resolved)
  );

  // Stage 2: resolved product
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= mid_valid;
      if (mid_valid) product <= resolved;
    end
  end
endmodule

// File: rtl/wmp_checker.sv
module wmp_checker #(
  parameter int W  = 8,
  localparam int PW = 2 * W
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [W-1:0]  op_a,
  input logic [W-1:0]  op_b,
  input logic          mid_valid,
  input logic [PW-1:0] mid_sum,
  input logic [PW-1:0] mid_carry,
  input logic          out_valid,
  input logic [PW-1:0] product
);
  logic [PW-1:0] ea, eb, full_prod, pair_total;
  assign ea         = PW'(op_a);
  assign eb         = PW'(op_b);
  assign full_prod  = ea * eb;
  assign pair_total = mid_sum + mid_carry;

  a_r5_stage1_follow: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> mid_valid);
  a_r5_stage1_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !mid_valid);
  a_r5_stage2_follow: assert property (@(posedge clk) disable iff (rst)
    mid_valid |=> out_valid);
  a_r5_stage2_idle: assert property (@(posedge clk) disable iff (rst)
    !mid_valid |=> !out_valid);
  a_r2_pair_value: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> pair_total == $past(full_prod));
  a_r4_resolve: assert property (@(posedge clk) disable iff (rst)
    mid_valid |=> product == $past(pair_total));
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !mid_valid |=> $stable(product));
  a_r9_zero_rows: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_a == '0 || op_b == '0)) |=> (mid_sum == '0 && mid_carry == '0));
endmodule

bind wallace_mul_pipe wmp_checker #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .op_a     (op_a),
  .op_b     (op_b),
  .mid_valid(mid_valid),
  .mid_sum  (mid_sum),
  .mid_carry(mid_carry),
  .out_valid(out_valid),
  .product  (product)
);

// File: tb/sim_wallace_mul_pipe.sv
`timescale 1ns/1ps
module sim_wallace_mul_pipe;
  localparam int W  = 8;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [W-1:0]  op_a = '0;
  logic [W-1:0]  op_b = '0;
  logic          out_valid;
  logic [PW-1:0] product;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Bench pipeline model
  bit            m1_v = 0, m2_v = 0;
  logic [PW-1:0] m1_p = '0, m2_p = '0;

  always #2 clk = ~clk;

  wallace_mul_pipe #(.W(W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .product(product)
  );

  // Shift-and-add reference
  function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [PW-1:0] acc;
    acc = '0;
    for (int i = 0; i < W; i++)
      if (b[i]) acc = acc + (PW'(a) << i);
    return acc;
  endfunction

  task automatic check(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Check outputs against model, drive new inputs, advance model by one edge.
  task automatic step(input string tag, input bit v, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    check({tag, " valid"}, PW'(out_valid), PW'(m2_v));
    check({tag, " product"}, product, m2_p);
    in_valid = v;
    op_a = a;
    op_b = b;
    if (m1_v) m2_p = m1_p;
    m2_v = m1_v;
    m1_v = v;
    if (v) m1_p = ref_mul(a, b);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    m1_v = 0; m2_v = 0; m1_p = '0; m2_p = '0;
    @(negedge clk);
    rst = 1'b0;
    check("R7 reset out_valid", PW'(out_valid), '0);
    check("R7 reset product", product, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R7 initial out_valid", PW'(out_valid), '0);
    check("R7 initial product", product, '0);

    // Directed corners
    step("R9 zero a", 1, 8'd0, 8'd255);
    step("R9 zero b", 1, 8'd173, 8'd0);
    step("R3 all ones", 1, 8'd255, 8'd255);
    step("R1 single bit", 1, 8'd1, 8'd128);
    step("R1 msb rows", 1, 8'd128, 8'd128);
    step("R3 alternating", 1, 8'h55, 8'hAA);
    step("R8 idle", 0, 8'd9, 8'd9);
    step("R8 idle", 0, 8'd7, 8'd3);
    step("R8 idle hold", 0, 8'd0, 8'd0);
    step("R5 single", 1, 8'd200, 8'd3);
    step("R5 drain", 0, 8'd0, 8'd0);
    step("R5 drain", 0, 8'd0, 8'd0);
    step("R5 drain", 0, 8'd0, 8'd0);

    // Exhaustive back-to-back sweep
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        step("R6 R4 sweep", 1, W'(a), W'(b));

    // Reset while traffic is in flight
    step("R6 pre-reset", 1, 8'd77, 8'd91);
    do_reset();

    // Gapped random traffic, fixed seed
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] ra, rb;
      bit rv;
      ra = W'($urandom);
      rb = W'($urandom);
      rv = ($urandom % 4) != 0;
      step("R8 R2 random", rv, ra, rb);
    end
    for (int n = 0; n < 3; n++) step("R5 final drain", 0, '0, '0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule